// File: doc/BRIEF.md
# Load-Delay Register Hazard Classifier

This block sits beside the issue logic of an in-order pipeline that has a load delay slot. A load is pending whose result will land in a known destination register, and the next instruction word is being examined. The block decodes which register fields that next instruction reads and which it writes. It then reports how the instruction touches the pending destination as a 2-bit class. The pipeline controller uses the class to decide whether the delay-slot instruction must see the register's old value, its new value, or a mix of the two. The forwarding muxes and the controller are outside this block.

The decode is purely combinational. The result is captured in a register on the cycle that the input strobe is high. It appears on the following cycle together with a single-cycle output-valid pulse, and it holds its value until the next strobe.

Top module: `ldh_classifier`

## Requirements
- R1: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high. `out_class` takes the class of the strobed inputs one cycle after the strobe and holds its value while `in_valid` is low.
- R2: While `rst` is high and after it is released, `out_valid` is 0 and `out_class` is 0 until the first strobe.
- R3: Class encoding is 0 none, 1 both read and written, 2 read only, 3 written only. An all-zero instruction word gives class 0 for any destination. Fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11] and function [5:0]. Opcode 0 selects the function-coded register group.
- R4: In the register group, the ALU functions 0x20–0x27, 0x2A and 0x2B and the variable shifts 0x04, 0x06 and 0x07 write rd and read rs and rt. If both a write and a read match, the class is 1. If only a read matches, it is 2. If only the write matches, it is 3.
- R5: The constant shifts (functions 0x00, 0x02, 0x03) write rd and read rt, with the R4 priority. The moves from the multiply result (0x10, 0x12) only write rd. The moves to it (0x11, 0x13) only read rs.
- R6: Multiply and divide (functions 0x18–0x1B) give class 2 when rs or rt matches, and never 1 or 3.
- R7: The immediate ALU opcodes 0x08–0x0E and the full loads 0x20, 0x21, 0x23, 0x24, 0x25 write rt and read rs, with the R4 priority.
- R8: For the partial-word loads 0x22 and 0x26, an rt match gives 3 even when rs also matches. Otherwise an rs match gives 2. Class 1 never occurs.
- R9: Stores (opcodes 0x28, 0x29, 0x2A, 0x2B, 0x2E) give 2 on an rs or rt match. Coprocessor-2 word transfers (0x32, 0x3A) give 2 only on an rs match.
- R10: Jump-and-link (opcode 0x03) gives 3 when the destination is register 31 and 0 otherwise.
- R11: Every other opcode or function gives 0, whatever the fields hold. This includes system call (0x0C), break (0x0D), the register jump and the conditional branches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: classify the current inputs |
| load_dst | input | 5 | Destination register of the pending load |
| next_insn | input | 32 | Instruction word that follows the load |
| out_valid | output | 1 | One-cycle pulse marking a new class |
| out_class | output | 2 | Interaction class (0 none, 1 both, 2 read, 3 write) |

## Verification
Directed words place the destination in each field in turn: rd only, rs only, rt only, and two fields at once. These show whether the priority between both, read-only and write-only is ordered correctly, and whether each instruction group reads and writes the right fields. Partial loads with rt equal to rs separate write-first ordering from the common priority. Store, coprocessor and link cases catch a field wrongly treated as written. A long stream of words, built from a small pool of register numbers so that matches are frequent, mixes strobed and idle cycles. It is compared each cycle with a behavioural model, which exposes hold and pulse-timing errors.

// File: rtl/ldh_pkg.sv
package ldh_pkg;

    localparam int WORD_W  = 32;
    localparam int REG_W   = 5;
    localparam int OPC_W   = 6;
    localparam int FN_W    = 6;
    localparam int OPC_LSB = WORD_W - OPC_W;
    localparam int RS_LSB  = OPC_LSB - REG_W;
    localparam int RT_LSB  = RS_LSB - REG_W;
    localparam int RD_LSB  = RT_LSB - REG_W;
    localparam int NUM_FIELDS = 3;

    typedef logic [REG_W-1:0] reg_idx_t;
    typedef logic [OPC_W-1:0] opc_t;
    typedef logic [FN_W-1:0]  fn_t;

    typedef enum logic [1:0] {
        HZ_NONE  = 2'd0,
        HZ_BOTH  = 2'd1,
        HZ_READ  = 2'd2,
        HZ_WRITE = 2'd3
    } hz_class_e;

    typedef struct packed {
        opc_t     opc;
        reg_idx_t rs;
        reg_idx_t rt;
        reg_idx_t rd;
        fn_t      fn;
        logic     blank;
    } insn_fields_t;

    typedef struct packed {
        logic rd_rs;
        logic rd_rt;
        logic wr_rd;
        logic wr_rt;
        logic wr_link;
        logic write_first;
    } field_use_t;

    localparam opc_t OPC_REGGRP  = 6'h00;
    localparam opc_t OPC_CALL    = 6'h03;
    localparam opc_t OPC_LD_LEFT = 6'h22;
    localparam opc_t OPC_LD_RGT  = 6'h26;

    function automatic field_use_t use_of_fn(fn_t fn);
        field_use_t u;
        u = '0;
        unique case (fn)
            6'h00, 6'h02, 6'h03: begin
                u.wr_rd = 1'b1;
                u.rd_rt = 1'b1;
            end
            6'h04, 6'h06, 6'h07,
            6'h20, 6'h21, 6'h22, 6'h23,
            6'h24, 6'h25, 6'h26, 6'h27,
            6'h2A, 6'h2B: begin
                u.wr_rd = 1'b1;
                u.rd_rs = 1'b1;
                u.rd_rt = 1'b1;
            end
            6'h10, 6'h12: u.wr_rd = 1'b1;
            6'h11, 6'h13: u.rd_rs = 1'b1;
            6'h18, 6'h19, 6'h1A, 6'h1B: begin
                u.rd_rs = 1'b1;
                u.rd_rt = 1'b1;
            end
            default: u = '0;
        endcase
        return u;
    endfunction

    function automatic field_use_t use_of_opc(opc_t opc);
        field_use_t u;
        u = '0;
        unique case (opc)
            OPC_CALL: u.wr_link = 1'b1;
            6'h08, 6'h09, 6'h0A, 6'h0B, 6'h0C, 6'h0D, 6'h0E,
            6'h20, 6'h21, 6'h23, 6'h24, 6'h25: begin
                u.wr_rt = 1'b1;
                u.rd_rs = 1'b1;
            end
            OPC_LD_LEFT, OPC_LD_RGT: begin
                u.wr_rt       = 1'b1;
                u.rd_rs       = 1'b1;
                u.write_first = 1'b1;
            end
            6'h28, 6'h29, 6'h2A, 6'h2B, 6'h2E: begin
                u.rd_rs = 1'b1;
                u.rd_rt = 1'b1;
            end
            6'h32, 6'h3A: u.rd_rs = 1'b1;
            default: u = '0;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/ldh_fields.sv
module ldh_fields
    import ldh_pkg::*;
(
    input  logic [WORD_W-1:0] insn,
    output insn_fields_t      fields
);
    always_comb begin
        fields.opc   = insn[OPC_LSB +: OPC_W];
        fields.rs    = insn[RS_LSB  +: REG_W];
        fields.rt    = insn[RT_LSB  +: REG_W];
        fields.rd    = insn[RD_LSB  +: REG_W];
        fields.fn    = insn[0       +: FN_W];
        fields.blank = (insn == '0);
    end
endmodule

// File: rtl/ldh_usage.sv
module ldh_usage
    import ldh_pkg::*;
(
    input  insn_fields_t fields,
    output field_use_t   use_o
);
    always_comb begin
        if (fields.blank) begin
            use_o = '0;
        end else if (fields.opc == OPC_REGGRP) begin
            use_o = use_of_fn(fields.fn);
        end else begin
            use_o = use_of_opc(fields.opc);
        end
    end
endmodule

// File: rtl/ldh_match.sv
module ldh_match
    import ldh_pkg::*;
#(
    parameter int LINK_REG = 31
) (
    input  reg_idx_t     dst,
    input  insn_fields_t fields,
    input  field_use_t   use_i,
    output logic         read_hit,
    output logic         write_hit
);
    localparam reg_idx_t LINK_IDX = reg_idx_t'(LINK_REG);

    reg_idx_t fld   [NUM_FIELDS];
    logic     rd_en [NUM_FIELDS];
    logic     wr_en [NUM_FIELDS];
    logic [NUM_FIELDS-1:0] rd_hit_v;
    logic [NUM_FIELDS-1:0] wr_hit_v;

    always_comb begin
        fld[0] = fields.rs;  rd_en[0] = use_i.rd_rs; wr_en[0] = 1'b0;
        fld[1] = fields.rt;  rd_en[1] = use_i.rd_rt; wr_en[1] = use_i.wr_rt;
        fld[2] = fields.rd;  rd_en[2] = 1'b0;        wr_en[2] = use_i.wr_rd;
    end

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cmp
        logic same;
        assign same        = (fld[g] == dst);
        assign rd_hit_v[g] = same && rd_en[g];
        assign wr_hit_v[g] = same && wr_en[g];
    end

    assign read_hit  = |rd_hit_v;
    assign write_hit = (|wr_hit_v) || (use_i.wr_link && dst == LINK_IDX);
endmodule

// File: rtl/ldh_rank.sv
module ldh_rank
    import ldh_pkg::*;
(
    input  logic      read_hit,
    input  logic      write_hit,
    input  logic      write_first,
    output hz_class_e cls
);
    always_comb begin
        if (write_first) begin
            if (write_hit)     cls = HZ_WRITE;
            else if (read_hit) cls = HZ_READ;
            else               cls = HZ_NONE;
        end else begin
            if (read_hit && write_hit) cls = HZ_BOTH;
            else if (read_hit)         cls = HZ_READ;
            else if (write_hit)        cls = HZ_WRITE;
            else                       cls = HZ_NONE;
        end
    end
endmodule

// File: rtl/ldh_classifier.sv
module ldh_classifier
    import ldh_pkg::*;
#(
    parameter int LINK_REG = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [REG_W-1:0]  load_dst,
    input  logic [WORD_W-1:0] next_insn,
    output logic              out_valid,
    output logic [1:0]        out_class
);
    insn_fields_t fields;
    field_use_t   use_w;
    logic         read_hit;
    logic         write_hit;
    hz_class_e    cls_w;
    hz_class_e    cls_q;

    ldh_fields u_fields (.insn(next_insn), .fields(fields));
    ldh_usage  u_usage  (.fields(fields), .use_o(use_w));
    ldh_match #(.LINK_REG(LINK_REG)) u_match (
        .dst(load_dst), .fields(fields), .use_i(use_w),
        .read_hit(read_hit), .write_hit(write_hit)
    );
    ldh_rank u_rank (
        .read_hit(read_hit), .write_hit(write_hit),
        .write_first(use_w.write_first), .cls(cls_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            cls_q     <= HZ_NONE;
        end else begin
            out_valid <= in_valid;
            if (in_valid) cls_q <= cls_w;
        end
    end

    assign out_class = cls_q;

    AST_PULSE_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R1
    AST_NO_PULSE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_class)); // R1
    AST_BLANK_WORD: assert property (@(posedge clk) disable iff (rst)
        (in_valid && next_insn == '0) |=> out_class == 2'd0); // R3
    AST_PARTIAL_NO_BOTH: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (next_insn[31:26] == 6'h22 || next_insn[31:26] == 6'h26))
        |=> out_class != 2'd1); // R8
    AST_STORE_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (next_insn[31:26] == 6'h28 || next_insn[31:26] == 6'h29 ||
                      next_insn[31:26] == 6'h2A || next_insn[31:26] == 6'h2B ||
                      next_insn[31:26] == 6'h2E))
        |=> (out_class == 2'd0 || out_class == 2'd2)); // R9
    AST_LINK_WRITE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && next_insn[31:26] == 6'h03 && load_dst == 5'(LINK_REG))
        |=> out_class == 2'd3); // R10
endmodule

// File: tb/test_ldh_classifier.sv
`timescale 1ns/1ps
module test_ldh_classifier;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [4:0]  load_dst;
    logic [31:0] next_insn;
    logic        out_valid;
    logic [1:0]  out_class;

    int checks = 0;
    int errors = 0;
    int exp_hold = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ldh_classifier i_ldh_classifier (
        .clk(clk), .rst(rst), .in_valid(in_valid), .load_dst(load_dst),
        .next_insn(next_insn), .out_valid(out_valid), .out_class(out_class)
    );

    function automatic logic [31:0] rt_w(int fn, int rs, int rt, int rd);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
    endfunction

    function automatic logic [31:0] it_w(int op, int rs, int rt);
        return {6'(op), 5'(rs), 5'(rt), 16'h1234};
    endfunction

    function automatic int model(int r, logic [31:0] w);
        int op = int'(w[31:26]);
        int fn = int'(w[5:0]);
        bit s  = (int'(w[25:21]) == r);
        bit t  = (int'(w[20:16]) == r);
        bit d  = (int'(w[15:11]) == r);
        if (w == 32'd0) return 0;
        if (op == 0) begin
            if (fn == 0 || fn == 2 || fn == 3) return (d && t) ? 1 : t ? 2 : d ? 3 : 0;
            if (fn == 16 || fn == 18) return d ? 3 : 0;
            if (fn == 17 || fn == 19) return s ? 2 : 0;
            if (fn >= 24 && fn <= 27) return (s || t) ? 2 : 0;
            if ((fn >= 32 && fn <= 39) || fn == 42 || fn == 43 || fn == 4 || fn == 6 || fn == 7)
                return (d && (s || t)) ? 1 : (s || t) ? 2 : d ? 3 : 0;
            return 0;
        end
        if (op == 3) return (r == 31) ? 3 : 0;
        if ((op >= 8 && op <= 14) || op == 32 || op == 33 || op == 35 || op == 36 || op == 37)
            return (t && s) ? 1 : s ? 2 : t ? 3 : 0;
        if (op == 34 || op == 38) return t ? 3 : s ? 2 : 0;
        if (op == 40 || op == 41 || op == 42 || op == 43 || op == 46) return (s || t) ? 2 : 0;
        if (op == 50 || op == 58) return s ? 2 : 0;
        return 0;
    endfunction

    task automatic step(bit v, int r, logic [31:0] w, string tag);
        in_valid  = v;
        load_dst  = 5'(r);
        next_insn = w;
        if (v) exp_hold = model(r, w);
        @(negedge clk);
        checks++;
        if (out_valid !== v || int'(out_class) != exp_hold) begin
            errors++;
            $display("FAIL %s: valid=%0b class=%0d expected valid=%0b class=%0d (reg %0d word %h)",
                     tag, out_valid, out_class, v, exp_hold, r, w);
        end
    endtask

    initial begin
        #(5ns * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; load_dst = '0; next_insn = '0;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_class !== 2'd0) begin
            errors++;
            $display("FAIL R2: valid=%0b class=%0d expected 0/0", out_valid, out_class);
        end
        rst = 1'b0;
        step(0, 0, 32'd0, "R2");
        // R3 blank word
        step(1, 0, 32'd0, "R3");
        // R4 register ALU priority
        step(1, 5, rt_w(6'h21, 5, 6, 5), "R4");
        step(1, 5, rt_w(6'h21, 5, 6, 7), "R4");
        step(1, 7, rt_w(6'h21, 5, 6, 7), "R4");
        step(1, 9, rt_w(6'h21, 5, 6, 7), "R4");
        step(1, 6, rt_w(6'h06, 1, 6, 6), "R4");
        // R1 hold on idle
        step(0, 9, rt_w(6'h21, 9, 9, 9), "R1");
        step(0, 1, 32'd0, "R1");
        // R5 shifts and hi/lo moves
        step(1, 3, rt_w(6'h00, 0, 3, 3) | 32'h40, "R5");
        step(1, 4, rt_w(6'h02, 0, 3, 4), "R5");
        step(1, 3, rt_w(6'h03, 3, 2, 4), "R5");
        step(1, 8, rt_w(6'h10, 0, 0, 8), "R5");
        step(1, 8, rt_w(6'h11, 8, 0, 0), "R5");
        step(1, 8, rt_w(6'h12, 8, 8, 2), "R5");
        // R6 multiply/divide
        step(1, 9, rt_w(6'h18, 4, 9, 9), "R6");
        step(1, 4, rt_w(6'h1B, 4, 9, 0), "R6");
        // R7 immediate ALU and full loads
        step(1, 2, it_w(6'h23, 2, 2), "R7");
        step(1, 10, it_w(6'h0D, 1, 10), "R7");
        step(1, 1, it_w(6'h08, 1, 10), "R7");
        // R8 partial loads
        step(1, 12, it_w(6'h22, 12, 12), "R8");
        step(1, 12, it_w(6'h26, 12, 1), "R8");
        step(1, 1, it_w(6'h26, 12, 1), "R8");
        // R9 stores and coprocessor transfers
        step(1, 7, it_w(6'h2B, 3, 7), "R9");
        step(1, 3, it_w(6'h2E, 3, 7), "R9");
        step(1, 7, it_w(6'h32, 3, 7), "R9");
        step(1, 7, it_w(6'h3A, 7, 3), "R9");
        // R10 jump-and-link
        step(1, 31, {6'h03, 26'h0ABCDEF}, "R10");
        step(1, 30, {6'h03, 26'h3FFFFFF}, "R10");
        // R11 unlisted
        step(1, 5, rt_w(6'h0C, 5, 5, 5), "R11");
        step(1, 5, rt_w(6'h0D, 5, 5, 5), "R11");
        step(1, 5, it_w(6'h04, 5, 5), "R11");
        step(1, 5, rt_w(6'h08, 5, 5, 5), "R11");
        step(1, 5, it_w(6'h01, 5, 5), "R11");
        // R1 long mixed stream against the model
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] w;
            int r;
            w = $urandom;
            w[25:21] = 5'($urandom_range(0, 3) + 28);
            w[20:16] = 5'($urandom_range(0, 3) + 28);
            w[15:11] = 5'($urandom_range(0, 3) + 28);
            if ($urandom_range(0, 1) == 1) w[31:26] = 6'h00;
            if ($urandom_range(0, 40) == 0) w = 32'd0;
            r = $urandom_range(0, 3) + 28;
            step(($urandom_range(0, 3) != 0), r, w, "R1");
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule